// File: doc/BRIEF.md
# Interrupt Latency History Buffer

This block records, in a circular log, every interrupt that a processor accepts. For each interrupt line it holds the cycle count at which a peripheral last raised that line. When the processor accepts an interrupt, the block writes a log entry with the line id, the take cycle and the stored raise cycle. It also keeps a running count of raised interrupts, which counts both accepted interrupts and direct raise requests.

Software-style inspection happens through a readout walk. A start pulse places a cursor on the newest entry. Each read request then returns one entry, moving toward older entries. An entry carries its id, its take cycle, its latency (take minus raise), and its gap to the next-newer entry. The walk ends with a done pulse when it reaches an empty slot, meaning a take cycle of zero, or when every slot has been returned.

Top module: `irq_lat_log`

## Requirements
- R1: After reset the raised counter is 0, `rdValid` and `rdDone` are low, and every slot is empty. A walk started right after reset answers its first request with `rdDone`.
- R2: A pulse on `raiseEvt[i]` stores `cycleNow` as the raise time of line i and replaces any earlier value. An accepted entry for line i reports a latency equal to its take cycle minus the latest stored raise time.
- R3: When `raiseEvt[i]` and an acceptance of id i occur in the same cycle, the entry uses that cycle as its raise time, so its latency is 0.
- R4: Each acceptance writes its id and take cycle (`cycleNow`) at the write index. The index then advances and wraps to slot 0 after slot DEPTH-1. The log therefore holds the most recent DEPTH acceptances.
- R5: `raisedTotal` grows by one for each cycle with `acceptValid` and by one for each cycle with `directRaise`. It grows by two when both occur in the same cycle, and wraps at its width.
- R6: `rdStart` points the walk at the newest entry and takes priority over `rdReq` in the same cycle. During a walk, each `rdReq` gives `rdValid` one cycle later with the next entry, newest first.
- R7: A request that meets a slot whose take cycle is zero gives `rdDone` instead of `rdValid` one cycle later, and the walk ends.
- R8: The first entry of a walk has `rdGapValid` low and `rdGap` 0. Every later entry has `rdGapValid` high and `rdGap` equal to the previously returned take cycle minus its own take cycle.
- R9: When all DEPTH slots are filled, a walk returns exactly DEPTH entries, and the next request gives `rdDone`.
- R10: `rdReq` outside a walk produces neither `rdValid` nor `rdDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleNow | input | CYC_W | Current cycle count |
| raiseEvt | input | NUM_LINES | Per-line pulse: the line's pending bit was just set |
| directRaise | input | 1 | Direct raise request, counted only |
| acceptValid | input | 1 | An interrupt is accepted this cycle |
| acceptId | input | ID_W | Line id of the accepted interrupt |
| rdStart | input | 1 | Begin a readout walk at the newest entry |
| rdReq | input | 1 | Request the next entry of the walk |
| rdValid | output | 1 | Entry fields are valid |
| rdDone | output | 1 | Walk has ended |
| rdId | output | ID_W | Entry line id |
| rdTake | output | CYC_W | Entry take cycle |
| rdLatency | output | CYC_W | Take cycle minus raise cycle |
| rdGap | output | CYC_W | Newer take cycle minus this take cycle |
| rdGapValid | output | 1 | `rdGap` is meaningful (not the first entry) |
| raisedTotal | output | CNT_W | Count of raised interrupts |

## Verification
Two pairs of events can collide in one cycle. The first pair is a raise and an acceptance on the same line. The bench drives both together and expects a zero-latency entry rather than one paired with the older timestamp. The second pair is an acceptance and a direct raise arriving together, which the bench provokes and judges by a jump of two in the counter. A behavioural model updated at each edge predicts every output, and the bench compares the outputs against it one half-cycle later.

// File: rtl/irq_lat_log_pkg.sv
package irq_lat_log_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;      // write an entry at the write index
    logic emit;      // present the entry at the read index
    logic finish;    // walk ended
    logic firstOut;  // the entry being emitted is the first of the walk
  } ctlStrobe_t;
endpackage

// File: rtl/irq_lat_log_ctrl.sv
module irq_lat_log_ctrl
  import irq_lat_log_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int STEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acceptValid,
  input  logic             rdStart,
  input  logic             rdReq,
  input  logic             entryEmpty,
  output logic [IDX_W-1:0] wrPtr,
  output logic [IDX_W-1:0] rdPtr,
  output ctlStrobe_t       strobe
);
  logic              walking;
  logic [STEP_W-1:0] stepCnt;
  logic              walkEnd;

  function automatic logic [IDX_W-1:0] prevIdx(input logic [IDX_W-1:0] idx);
    return (idx == '0) ? IDX_W'(DEPTH - 1) : idx - 1'b1;
  endfunction

  assign walkEnd = (stepCnt == STEP_W'(DEPTH)) || entryEmpty;

  always_comb begin
    strobe          = '0;
    strobe.wrEn     = acceptValid;
    strobe.emit     = walking && rdReq && !rdStart && !walkEnd;
    strobe.finish   = walking && rdReq && !rdStart && walkEnd;
    strobe.firstOut = (stepCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (acceptValid) begin
      wrPtr <= (wrPtr == IDX_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walking <= 1'b0;
      rdPtr   <= '0;
      stepCnt <= '0;
    end else if (rdStart) begin
      walking <= 1'b1;
      rdPtr   <= prevIdx(wrPtr);
      stepCnt <= '0;
    end else if (strobe.finish) begin
      walking <= 1'b0;
    end else if (strobe.emit) begin
      rdPtr   <= prevIdx(rdPtr);
      stepCnt <= stepCnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_lat_log_dp.sv
module irq_lat_log_dp
  import irq_lat_log_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DEPTH = 16,
  parameter int CYC_W = 32,
  parameter int CNT_W = 16,
  localparam int ID_W = $clog2(NUM_LINES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CYC_W-1:0]     cycleNow,
  input  logic [NUM_LINES-1:0] raiseEvt,
  input  logic                 directRaise,
  input  logic                 acceptValid,
  input  logic [ID_W-1:0]      acceptId,
  input  logic [IDX_W-1:0]     wrPtr,
  input  logic [IDX_W-1:0]     rdPtr,
  input  ctlStrobe_t           strobe,
  output logic                 entryEmpty,
  output logic                 rdValid,
  output logic                 rdDone,
  output logic [ID_W-1:0]      rdId,
  output logic [CYC_W-1:0]     rdTake,
  output logic [CYC_W-1:0]     rdLatency,
  output logic [CYC_W-1:0]     rdGap,
  output logic                 rdGapValid,
  output logic [CNT_W-1:0]     raisedTotal
);
  logic [CYC_W-1:0] lineStamp [NUM_LINES];
  logic [ID_W-1:0]  logId     [DEPTH];
  logic [CYC_W-1:0] logTake   [DEPTH];
  logic [CYC_W-1:0] logRaise  [DEPTH];
  logic [CYC_W-1:0] prevTake;
  logic [CYC_W-1:0] acceptRaise;
  logic [CYC_W-1:0] curTake;

  // Per-line raise timestamps
  for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lineStamp[li] <= '0;
      else if (raiseEvt[li]) lineStamp[li] <= cycleNow;
    end
  end

  // Same-cycle raise on the accepted line takes the fresh cycle
  assign acceptRaise = raiseEvt[acceptId] ? cycleNow : lineStamp[acceptId];

  // Log slots
  for (genvar si = 0; si < DEPTH; si++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        logId[si]    <= '0;
        logTake[si]  <= '0;
        logRaise[si] <= '0;
      end else if (strobe.wrEn && wrPtr == IDX_W'(si)) begin
        logId[si]    <= acceptId;
        logTake[si]  <= cycleNow;
        logRaise[si] <= acceptRaise;
      end
    end
  end

  assign curTake    = logTake[rdPtr];
  assign entryEmpty = (curTake == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) raisedTotal <= '0;
    else raisedTotal <= raisedTotal + CNT_W'(acceptValid) + CNT_W'(directRaise);
  end

  // Readout registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid    <= 1'b0;
      rdDone     <= 1'b0;
      rdId       <= '0;
      rdTake     <= '0;
      rdLatency  <= '0;
      rdGap      <= '0;
      rdGapValid <= 1'b0;
      prevTake   <= '0;
    end else begin
      rdValid <= strobe.emit;
      rdDone  <= strobe.finish;
      if (strobe.emit) begin
        rdId       <= logId[rdPtr];
        rdTake     <= curTake;
        rdLatency  <= curTake - logRaise[rdPtr];
        rdGapValid <= !strobe.firstOut;
        rdGap      <= strobe.firstOut ? '0 : prevTake - curTake;
        prevTake   <= curTake;
      end
    end
  end
endmodule

// File: rtl/irq_lat_log.sv
module irq_lat_log
  import irq_lat_log_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DEPTH = 16,
  parameter int CYC_W = 32,
  parameter int CNT_W = 16,
  localparam int ID_W = $clog2(NUM_LINES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CYC_W-1:0]     cycleNow,
  input  logic [NUM_LINES-1:0] raiseEvt,
  input  logic                 directRaise,
  input  logic                 acceptValid,
  input  logic [ID_W-1:0]      acceptId,
  input  logic                 rdStart,
  input  logic                 rdReq,
  output logic                 rdValid,
  output logic                 rdDone,
  output logic [ID_W-1:0]      rdId,
  output logic [CYC_W-1:0]     rdTake,
  output logic [CYC_W-1:0]     rdLatency,
  output logic [CYC_W-1:0]     rdGap,
  output logic                 rdGapValid,
  output logic [CNT_W-1:0]     raisedTotal
);
  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] wrPtr;
  logic [IDX_W-1:0] rdPtr;
  logic             entryEmpty;

  irq_lat_log_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .acceptValid(acceptValid), .rdStart(rdStart),
    .rdReq(rdReq), .entryEmpty(entryEmpty), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .strobe(strobe)
  );

  irq_lat_log_dp #(
    .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .CYC_W(CYC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cycleNow(cycleNow), .raiseEvt(raiseEvt),
    .directRaise(directRaise), .acceptValid(acceptValid), .acceptId(acceptId),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .strobe(strobe), .entryEmpty(entryEmpty),
    .rdValid(rdValid), .rdDone(rdDone), .rdId(rdId), .rdTake(rdTake),
    .rdLatency(rdLatency), .rdGap(rdGap), .rdGapValid(rdGapValid),
    .raisedTotal(raisedTotal)
  );
endmodule

// File: rtl/irq_lat_log_chk.sv
module irq_lat_log_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             acceptValid,
  input logic             directRaise,
  input logic             rdStart,
  input logic             rdReq,
  input logic             rdValid,
  input logic             rdDone,
  input logic             rdGapValid,
  input logic [CNT_W-1:0] raisedTotal
);
  AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && rdDone));  // R6
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdReq) && !$past(rdStart)));  // R6
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> ($past(rdReq) && !$past(rdStart)));  // R7
  AST_NO_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdValid);  // R10
  AST_GAP_FLAG_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdStart, 2)) |-> !rdGapValid);  // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> raisedTotal == $past(raisedTotal)
      + CNT_W'($past(acceptValid)) + CNT_W'($past(directRaise)));  // R5
endmodule

bind irq_lat_log irq_lat_log_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .acceptValid(acceptValid), .directRaise(directRaise),
  .rdStart(rdStart), .rdReq(rdReq), .rdValid(rdValid), .rdDone(rdDone),
  .rdGapValid(rdGapValid), .raisedTotal(raisedTotal)
);

// File: tb/irq_lat_log_bench.sv
module irq_lat_log_bench;
  localparam int NL = 8;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cycleNow = 32'd1;
  logic [NL-1:0] raiseEvt = '0;
  logic        directRaise = 1'b0;
  logic        acceptValid = 1'b0;
  logic [2:0]  acceptId = '0;
  logic        rdStart = 1'b0;
  logic        rdReq = 1'b0;
  logic        rdValid, rdDone, rdGapValid;
  logic [2:0]  rdId;
  logic [31:0] rdTake, rdLatency, rdGap;
  logic [15:0] raisedTotal;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  irq_lat_log u_irq_lat_log (
    .clk(clk), .rstN(rstN), .cycleNow(cycleNow), .raiseEvt(raiseEvt),
    .directRaise(directRaise), .acceptValid(acceptValid), .acceptId(acceptId),
    .rdStart(rdStart), .rdReq(rdReq), .rdValid(rdValid), .rdDone(rdDone),
    .rdId(rdId), .rdTake(rdTake), .rdLatency(rdLatency), .rdGap(rdGap),
    .rdGapValid(rdGapValid), .raisedTotal(raisedTotal)
  );

  // Behavioural reference model
  bit [2:0]  mId [DEPTH];
  bit [31:0] mTake [DEPTH];
  bit [31:0] mRaise [DEPTH];
  bit [31:0] mStamp [NL];
  int        mWr, mCur, mSteps;
  bit        mWalk;
  bit [31:0] mPrev;
  bit [15:0] mCnt;
  bit        expValid, expDone, eGapV;
  bit [2:0]  eId;
  bit [31:0] eTake, eLat, eGap;
  string     tagV = "R6";
  string     tagD = "R7";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin mId[i] = 0; mTake[i] = 0; mRaise[i] = 0; end
      for (int i = 0; i < NL; i++) mStamp[i] = 0;
      mWr = 0; mCur = 0; mSteps = 0; mWalk = 0; mPrev = 0; mCnt = 0;
      expValid = 0; expDone = 0; tagV = "R1"; tagD = "R1";
    end else begin
      expValid = 0; expDone = 0; tagV = "R6"; tagD = "R7";
      if (rdStart) begin
        mWalk = 1; mCur = (mWr + DEPTH - 1) % DEPTH; mSteps = 0;
      end else if (rdReq) begin
        if (!mWalk) begin
          tagV = "R10"; tagD = "R10";
        end else if (mSteps == DEPTH || mTake[mCur] == 0) begin
          expDone = 1; mWalk = 0;
          if (mSteps == DEPTH) tagD = "R9";
        end else begin
          expValid = 1;
          eId = mId[mCur]; eTake = mTake[mCur]; eLat = mTake[mCur] - mRaise[mCur];
          eGapV = (mSteps != 0); eGap = eGapV ? mPrev - eTake : 0;
          mPrev = eTake; mCur = (mCur + DEPTH - 1) % DEPTH; mSteps++;
        end
      end
      if (acceptValid) begin
        mId[mWr] = acceptId; mTake[mWr] = cycleNow;
        mRaise[mWr] = raiseEvt[acceptId] ? cycleNow : mStamp[acceptId];
        mWr = (mWr + 1) % DEPTH; mCnt++;
      end
      if (directRaise) mCnt++;
      for (int i = 0; i < NL; i++) if (raiseEvt[i]) mStamp[i] = cycleNow;
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Advance one clock, compare at the falling edge, clear pulses
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(tagV, "rdValid", rdValid, expValid);
    chk(tagD, "rdDone", rdDone, expDone);
    chk("R5", "raisedTotal", raisedTotal, mCnt);
    if (expValid) begin
      chk(curTag, "rdId", rdId, eId);
      chk(curTag, "rdTake", rdTake, eTake);
      chk(curTag, "rdLatency", rdLatency, eLat);
      chk("R8", "rdGapValid", rdGapValid, eGapV);
      chk("R8", "rdGap", rdGap, eGap);
    end
    raiseEvt = '0; directRaise = 0; acceptValid = 0; rdStart = 0; rdReq = 0;
    cycleNow = cycleNow + 1;
  endtask

  task automatic walkAll(string tag);
    curTag = tag;
    rdStart = 1; step();
    for (int k = 0; k < DEPTH + 2; k++) begin
      rdReq = 1; step();
      if (expDone) break;
    end
  endtask

  task automatic accept(int id); acceptValid = 1; acceptId = 3'(id); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] lcg = 32'h1234_5678;
    repeat (3) step();
    rstN = 1;
    @(negedge clk);
    chk("R1", "raisedTotal after reset", raisedTotal, 0);
    chk("R1", "rdValid after reset", rdValid, 0);
    chk("R1", "rdDone after reset", rdDone, 0);
    walkAll("R1");
    chk("R1", "empty walk ends at once", rdDone, 1);

    // R10: requests outside a walk
    curTag = "R10";
    rdReq = 1; step();
    rdReq = 1; step();

    // R2: latest raise wins
    raiseEvt[3] = 1; step();
    step(); step();
    raiseEvt[3] = 1; raiseEvt[5] = 1; step();
    repeat (4) step();
    accept(3); step();
    step();
    accept(5); step();
    walkAll("R2");

    // R3 and R5: raise and accept same line, plus direct raise, same cycle
    raiseEvt[2] = 1; accept(2); directRaise = 1; step();
    directRaise = 1; step();
    walkAll("R3");

    // R6: restart during walk, request together with start
    curTag = "R6";
    rdStart = 1; step();
    rdReq = 1; step();
    rdStart = 1; rdReq = 1; step();
    walkAll("R6");

    // R4 / R9: overfill the log
    for (int n = 0; n < DEPTH + 3; n++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      raiseEvt = lcg[NL+7:8];
      if (lcg[20]) directRaise = 1;
      step();
      repeat (int'(lcg[18:17])) step();
      accept(int'(lcg[26:24]));
      if (lcg[27]) raiseEvt[lcg[26:24]] = 1;
      step();
    end
    walkAll("R4");

    // R1: reset mid-run empties the log
    rstN = 0; step();
    rstN = 1; step();
    chk("R1", "raisedTotal after second reset", raisedTotal, 0);
    walkAll("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule